// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Controller

This block settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline. It holds the fetch-to-decode slot and pulls the branch condition, the two source register indices and the offset out of the instruction word. It then compares the two operands, choosing for each one between the register file, the memory-stage result and the write-back-stage result, and adds the sign-extended offset to the decode PC to form the target. Deciding in decode means a taken branch wastes only the one instruction being fetched behind it.

The price is earlier data dependencies. An ALU producer still in execute holds the branch in decode for one cycle, after which its result is forwarded from the memory stage. A load producer holds it for two cycles, because its data exists only once the load reaches write-back. While the branch waits, the controller freezes fetch and decode and sends a bubble into execute. A branch is never resolved in a stalled cycle.

Top module: `brc_branch_ctrl`

## Requirements
- R1: After reset the decode slot holds the no-operation word 0x00000013 with PC 0, and stall, bubble and redirect are all low.
- R2: A branch in decode whose sources match no pending write resolves in its first decode cycle with zero stalls, and both forwarding selects read 0 (register file).
- R3: A word with opcode bits [6:0] = 1100011 is a branch. Its condition is bits [14:12]: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. Codes 010 and 011 are treated as non-branches. The first operand is the register in bits [19:15] and the second is the register in bits [24:20].
- R4: The redirect address equals the decode PC plus the sign-extended 13-bit offset {w[31], w[7], w[30:25], w[11:8], 0}.
- R5: When a branch is taken in a cycle without stall, redirect_valid and flush_if are high, and on the next cycle the decode slot holds 0x00000013 instead of the fetched word. A branch that is not taken lets the fetched word into decode.
- R6: A non-load producer in execute with write enable and a matching destination causes exactly one stall cycle. After that stall the matching operand's select reads 1 (memory-stage value).
- R7: A load producer with a matching destination causes a stall while it is in execute and again while it is in memory, for two stall cycles in total. After that the operand's select reads 2 (write-back value).
- R8: A destination of register 0, or a producer whose write flag is low, never causes a stall or a forward.
- R9: In a stall cycle, redirect and flush stay low, bubble_ex is high, and the decode slot keeps its word and PC across the clock edge.
- R10: A non-branch word in decode never stalls and never redirects, whatever the producers are.
- R11: When both the memory stage (non-load) and the write-back stage match an operand, the memory stage is selected. The select code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word | input | 32 | Instruction word currently being fetched |
| fetch_pc | input | XLEN | PC of the fetched word |
| rf_rs1_val | input | XLEN | Register-file value of the first source |
| rf_rs2_val | input | XLEN | Register-file value of the second source |
| mem_fwd_val | input | XLEN | Result held by the memory stage |
| wb_fwd_val | input | XLEN | Result held by the write-back stage |
| ex_rd | input | 5 | Destination index in execute |
| ex_wr | input | 1 | Execute stage writes a register |
| mem_rd | input | 5 | Destination index in memory |
| mem_wr | input | 1 | Memory stage writes a register |
| mem_load | input | 1 | Memory stage instruction is a load |
| wb_rd | input | 5 | Destination index in write-back |
| wb_wr | input | 1 | Write-back stage writes a register |
| dec_word | output | 32 | Instruction word in decode |
| dec_pc | output | XLEN | PC of the decode word |
| stall_fd | output | 1 | Hold the PC and the decode slot |
| bubble_ex | output | 1 | Insert a no-operation into execute |
| flush_if | output | 1 | Kill the word being fetched |
| redirect_valid | output | 1 | Branch taken; load redirect_pc |
| redirect_pc | output | XLEN | Branch target |
| fwd_sel_a | output | 2 | First operand source: 0 file, 1 memory, 2 write-back |
| fwd_sel_b | output | 2 | Second operand source: 0 file, 1 memory, 2 write-back |

## Verification
The assertions assume that the stage inputs describe an in-order pipeline moving exactly as the controller orders. When stall_fd is high, a producer moves from execute to memory and then to write-back, and a bubble fills execute. The assertions also assume that all inputs are stable between edges. The bench keeps to this by driving the execute, memory and write-back fields from its own small shift model, advanced once per clock. During every stall and every cycle in which an operand is not yet valid, it supplies a deliberately wrong value on the memory and write-back inputs, so only the correct select can produce the expected outcome.

// File: rtl/brc_pkg.sv
package brc_pkg;

  localparam int unsigned INSN_W    = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned OFF_W     = 13;

  localparam logic [INSN_W-1:0] NOP_INSN    = 32'h0000_0013;
  localparam logic [6:0]        OPC_COND_BR = 7'b110_0011;

  typedef enum logic [2:0] {
    COND_EQ  = 3'b000,
    COND_NE  = 3'b001,
    COND_LT  = 3'b100,
    COND_GE  = 3'b101,
    COND_LTU = 3'b110,
    COND_GEU = 3'b111
  } brc_cond_e;

  typedef enum logic [1:0] {
    OPND_RF  = 2'd0,
    OPND_MEM = 2'd1,
    OPND_WB  = 2'd2
  } brc_opnd_src_e;

  function automatic logic cond_supported(input logic [2:0] code);
    return (code[2:1] != 2'b01);
  endfunction

endpackage

// File: rtl/brc_rst_sync.sv
module brc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/brc_dec_slot.sv
module brc_dec_slot
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              kill,
  input  logic [INSN_W-1:0] fetch_word,
  input  logic [XLEN-1:0]   fetch_pc,
  output logic [INSN_W-1:0] slot_word,
  output logic [XLEN-1:0]   slot_pc
);

  logic              load_en;
  logic [INSN_W-1:0] word_d;
  logic [XLEN-1:0]   pc_d;

  always_comb begin
    load_en = kill || !hold;
    word_d  = kill ? NOP_INSN : fetch_word;
    pc_d    = fetch_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_word <= NOP_INSN;
      slot_pc   <= '0;
    end else if (load_en) begin
      slot_word <= word_d;
      slot_pc   <= pc_d;
    end
  end

endmodule

// File: rtl/brc_hazard.sv
module brc_hazard
  import brc_pkg::*;
#(
  parameter int unsigned NSRC = 2
) (
  input  logic                            is_branch,
  input  logic [NSRC-1:0][REG_IDX_W-1:0]  src_idx,
  input  logic [REG_IDX_W-1:0]            ex_rd,
  input  logic                            ex_wr,
  input  logic [REG_IDX_W-1:0]            mem_rd,
  input  logic                            mem_wr,
  input  logic                            mem_load,
  input  logic [REG_IDX_W-1:0]            wb_rd,
  input  logic                            wb_wr,
  output logic                            stall,
  output logic [NSRC-1:0][1:0]            fwd_sel
);

  logic [NSRC-1:0] wait_v;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic live;
    logic hit_ex;
    logic hit_mem;
    logic hit_wb;

    assign live    = (src_idx[g] != '0);
    assign hit_ex  = live && ex_wr  && (ex_rd  == src_idx[g]);
    assign hit_mem = live && mem_wr && (mem_rd == src_idx[g]);
    assign hit_wb  = live && wb_wr  && (wb_rd  == src_idx[g]);

    // value not yet produced: any writer in execute, or a load still in memory
    assign wait_v[g] = hit_ex || (hit_mem && mem_load);

    assign fwd_sel[g] = (hit_mem && !mem_load) ? OPND_MEM :
                        hit_wb                 ? OPND_WB  : OPND_RF;
  end

  assign stall = is_branch && (|wait_v);

endmodule

// File: rtl/brc_resolve.sv
module brc_resolve
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            enable,
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic [XLEN-1:0] mem_val,
  input  logic [XLEN-1:0] wb_val,
  input  logic [1:0]      sel_a,
  input  logic [1:0]      sel_b,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] offset,
  output logic            taken,
  output logic [XLEN-1:0] target
);

  function automatic logic [XLEN-1:0] pick(input logic [1:0] sel,
                                           input logic [XLEN-1:0] rf,
                                           input logic [XLEN-1:0] mv,
                                           input logic [XLEN-1:0] wv);
    case (brc_opnd_src_e'(sel))
      OPND_MEM: return mv;
      OPND_WB:  return wv;
      default:  return rf;
    endcase
  endfunction

  logic [XLEN-1:0] opa;
  logic [XLEN-1:0] opb;
  logic            equal;
  logic            less_s;
  logic            less_u;
  logic            hit;

  always_comb begin
    opa    = pick(sel_a, rf_a, mem_val, wb_val);
    opb    = pick(sel_b, rf_b, mem_val, wb_val);
    equal  = (opa == opb);
    less_s = ($signed(opa) < $signed(opb));
    less_u = (opa < opb);
    case (brc_cond_e'(cond))
      COND_EQ:  hit = equal;
      COND_NE:  hit = !equal;
      COND_LT:  hit = less_s;
      COND_GE:  hit = !less_s;
      COND_LTU: hit = less_u;
      COND_GEU: hit = !less_u;
      default:  hit = 1'b0;
    endcase
    taken  = enable && hit;
    target = pc + offset;
  end

endmodule

// File: rtl/brc_branch_ctrl.sv
module brc_branch_ctrl
  import brc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [INSN_W-1:0]    fetch_word,
  input  logic [XLEN-1:0]      fetch_pc,
  input  logic [XLEN-1:0]      rf_rs1_val,
  input  logic [XLEN-1:0]      rf_rs2_val,
  input  logic [XLEN-1:0]      mem_fwd_val,
  input  logic [XLEN-1:0]      wb_fwd_val,
  input  logic [REG_IDX_W-1:0] ex_rd,
  input  logic                 ex_wr,
  input  logic [REG_IDX_W-1:0] mem_rd,
  input  logic                 mem_wr,
  input  logic                 mem_load,
  input  logic [REG_IDX_W-1:0] wb_rd,
  input  logic                 wb_wr,
  output logic [INSN_W-1:0]    dec_word,
  output logic [XLEN-1:0]      dec_pc,
  output logic                 stall_fd,
  output logic                 bubble_ex,
  output logic                 flush_if,
  output logic                 redirect_valid,
  output logic [XLEN-1:0]      redirect_pc,
  output logic [1:0]           fwd_sel_a,
  output logic [1:0]           fwd_sel_b
);

  localparam int unsigned NSRC    = 2;
  localparam int unsigned EXT_W   = XLEN - OFF_W;

  logic                           rst_n_int;
  logic [6:0]                     dec_opc;
  logic [2:0]                     dec_cond;
  logic                           dec_is_br;
  logic [OFF_W-1:0]               dec_off;
  logic [XLEN-1:0]                dec_off_ext;
  logic [NSRC-1:0][REG_IDX_W-1:0] src_idx;
  logic [NSRC-1:0][1:0]           sel;
  logic                           hz_stall;
  logic                           taken;
  logic [XLEN-1:0]                target;

  brc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  brc_dec_slot #(.XLEN(XLEN)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .hold       (hz_stall),
    .kill       (taken),
    .fetch_word (fetch_word),
    .fetch_pc   (fetch_pc),
    .slot_word  (dec_word),
    .slot_pc    (dec_pc)
  );

  always_comb begin
    dec_opc     = dec_word[6:0];
    dec_cond    = dec_word[14:12];
    dec_is_br   = (dec_opc == OPC_COND_BR) && cond_supported(dec_cond);
    src_idx[0]  = dec_word[19:15];
    src_idx[1]  = dec_word[24:20];
    dec_off     = {dec_word[31], dec_word[7], dec_word[30:25], dec_word[11:8], 1'b0};
    dec_off_ext = {{EXT_W{dec_off[OFF_W-1]}}, dec_off};
  end

  brc_hazard #(.NSRC(NSRC)) u_hazard (
    .is_branch (dec_is_br),
    .src_idx   (src_idx),
    .ex_rd     (ex_rd),
    .ex_wr     (ex_wr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_load  (mem_load),
    .wb_rd     (wb_rd),
    .wb_wr     (wb_wr),
    .stall     (hz_stall),
    .fwd_sel   (sel)
  );

  brc_resolve #(.XLEN(XLEN)) u_resolve (
    .enable  (dec_is_br && !hz_stall),
    .cond    (dec_cond),
    .rf_a    (rf_rs1_val),
    .rf_b    (rf_rs2_val),
    .mem_val (mem_fwd_val),
    .wb_val  (wb_fwd_val),
    .sel_a   (sel[0]),
    .sel_b   (sel[1]),
    .pc      (dec_pc),
    .offset  (dec_off_ext),
    .taken   (taken),
    .target  (target)
  );

  assign stall_fd       = hz_stall;
  assign bubble_ex      = hz_stall;
  assign flush_if       = taken;
  assign redirect_valid = taken;
  assign redirect_pc    = target;
  assign fwd_sel_a      = sel[0];
  assign fwd_sel_b      = sel[1];

endmodule

// File: rtl/brc_branch_ctrl_chk.sv
module brc_branch_ctrl_chk
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [REG_IDX_W-1:0] ex_rd,
  input logic                 ex_wr,
  input logic [REG_IDX_W-1:0] mem_rd,
  input logic                 mem_wr,
  input logic                 mem_load,
  input logic [INSN_W-1:0]    dec_word,
  input logic [XLEN-1:0]      dec_pc,
  input logic                 stall_fd,
  input logic                 bubble_ex,
  input logic                 flush_if,
  input logic                 redirect_valid,
  input logic [XLEN-1:0]      redirect_pc,
  input logic [1:0]           fwd_sel_a,
  input logic [1:0]           fwd_sel_b
);

  logic                 chk_is_br;
  logic [REG_IDX_W-1:0] chk_rs1;
  logic [REG_IDX_W-1:0] chk_rs2;

  assign chk_is_br = (dec_word[6:0] == OPC_COND_BR) && (dec_word[13] == 1'b0 || dec_word[14] == 1'b1);
  assign chk_rs1   = dec_word[19:15];
  assign chk_rs2   = dec_word[24:20];

  // R9
  stall_blocks_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |-> (!redirect_valid && !flush_if && bubble_ex));

  // R9
  stall_holds_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |=> (dec_word == $past(dec_word) && dec_pc == $past(dec_pc)));

  // R5
  flush_gives_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_if |=> (dec_word == NOP_INSN));

  // R4
  target_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_pc[0] == 1'b0));

  // R10
  nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_word[6:0] != OPC_COND_BR) |-> (!stall_fd && !redirect_valid));

  // R7
  load_in_mem_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_is_br && mem_wr && mem_load && mem_rd != '0 && mem_rd == chk_rs1) |-> stall_fd);

  // R6
  ex_writer_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_is_br && ex_wr && ex_rd != '0 && ex_rd == chk_rs2) |-> stall_fd);

  // R11
  sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a != 2'd3) && (fwd_sel_b != 2'd3));

endmodule

bind brc_branch_ctrl brc_branch_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ex_rd          (ex_rd),
  .ex_wr          (ex_wr),
  .mem_rd         (mem_rd),
  .mem_wr         (mem_wr),
  .mem_load       (mem_load),
  .dec_word       (dec_word),
  .dec_pc         (dec_pc),
  .stall_fd       (stall_fd),
  .bubble_ex      (bubble_ex),
  .flush_if       (flush_if),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .fwd_sel_a      (fwd_sel_a),
  .fwd_sel_b      (fwd_sel_b)
);

// File: tb/brc_branch_ctrl_tb_top.sv
module brc_branch_ctrl_tb_top;

  localparam logic [31:0] NOP  = 32'h0000_0013;
  localparam logic [31:0] FALL = 32'h0110_0393;
  localparam logic [31:0] TGTW = 32'h0330_0E93;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_word, fetch_pc, rf_rs1_val, rf_rs2_val, mem_fwd_val, wb_fwd_val;
  logic [4:0]  ex_rd, mem_rd, wb_rd;
  logic        ex_wr, mem_wr, mem_load, wb_wr;
  logic [31:0] dec_word, dec_pc, redirect_pc;
  logic        stall_fd, bubble_ex, flush_if, redirect_valid;
  logic [1:0]  fwd_sel_a, fwd_sel_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic ex_ld;

  always #4 clk = ~clk;

  brc_branch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .fetch_pc(fetch_pc),
    .rf_rs1_val(rf_rs1_val), .rf_rs2_val(rf_rs2_val),
    .mem_fwd_val(mem_fwd_val), .wb_fwd_val(wb_fwd_val),
    .ex_rd(ex_rd), .ex_wr(ex_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_load(mem_load), .wb_rd(wb_rd), .wb_wr(wb_wr),
    .dec_word(dec_word), .dec_pc(dec_pc), .stall_fd(stall_fd),
    .bubble_ex(bubble_ex), .flush_if(flush_if), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bword(input logic [2:0] f3, input logic [4:0] r1,
                                        input logic [4:0] r2, input logic [12:0] im);
    return {im[12], im[10:5], r2, r1, f3, im[4:1], im[11], 7'b110_0011};
  endfunction

  function automatic logic exp_take(input int f3, input logic [31:0] a, input logic [31:0] b);
    case (f3)
      0: return a == b;
      1: return a != b;
      4: return $signed(a) <  $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return a <  b;
      7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic idle_stages();
    ex_rd = 0; ex_wr = 0; ex_ld = 0;
    mem_rd = 0; mem_wr = 0; mem_load = 0;
    wb_rd = 0; wb_wr = 0;
  endtask

  // shift model: the producer moves one stage, a bubble fills execute
  task automatic adv(input int kind, inout int pos, input logic [31:0] good);
    wb_rd = mem_rd; wb_wr = mem_wr;
    mem_rd = ex_rd; mem_wr = ex_wr; mem_load = ex_ld;
    ex_rd = 0; ex_wr = 0; ex_ld = 0;
    pos++;
    mem_fwd_val = (pos == 1 && kind == 1) ? good : (good ^ 32'h8000_0001);
    wb_fwd_val  = (pos == 2) ? good : (good ^ 32'h8000_0001);
  endtask

  // kind 0: no producer, 1: ALU producer in execute, 2: load producer in execute
  task automatic run_case(input int kind, input int dep, input int f3,
                          input logic [31:0] a, input logic [31:0] b, input int imm);
    logic [31:0] w, pc, good, tgt;
    logic        tk;
    int          stalls, pos;
    string       rq;
    pc   = 32'h0000_2000;
    w    = bword(3'(f3), 5'd5, 5'd6, 13'(imm));
    good = dep ? b : a;
    tgt  = pc + 32'(imm);
    tk   = exp_take(f3, a, b);
    rq   = (kind == 0) ? "R2" : (kind == 1) ? "R6" : "R7";
    pos  = 0;
    @(posedge clk); #1;
    idle_stages();
    fetch_word = w; fetch_pc = pc;
    rf_rs1_val = a; rf_rs2_val = b;
    mem_fwd_val = good ^ 32'h8000_0001; wb_fwd_val = good ^ 32'h8000_0001;
    @(posedge clk); #1;
    fetch_word = FALL; fetch_pc = pc + 4;
    if (kind != 0) begin
      ex_rd = dep ? 5'd6 : 5'd5; ex_wr = 1; ex_ld = (kind == 2);
      if (dep) rf_rs2_val = good ^ 32'h8000_0001;
      else     rf_rs1_val = good ^ 32'h8000_0001;
    end
    stalls = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!stall_fd) break;
      stalls++;
      chk("R9", "decode word held", dec_word, w);
      chk("R9", "no redirect in stall", {31'd0, redirect_valid}, 32'd0);
      chk("R9", "bubble in stall", {31'd0, bubble_ex}, 32'd1);
      @(posedge clk); #1;
      adv(kind, pos, good);
    end
    chk(rq, "stall count", stalls, kind);
    chk(rq, "dependent select", dep ? fwd_sel_b : fwd_sel_a, kind);
    chk("R2", "other select", dep ? fwd_sel_a : fwd_sel_b, 0);
    chk("R3", "taken", {31'd0, redirect_valid}, {31'd0, tk});
    chk("R5", "flush", {31'd0, flush_if}, {31'd0, tk});
    if (tk) chk("R4", "target", redirect_pc, tgt);
    @(posedge clk); #1;
    adv(kind, pos, good);
    fetch_word = TGTW; fetch_pc = tk ? tgt : pc + 8;
    @(negedge clk);
    chk("R5", "word after branch", dec_word, tk ? NOP : FALL);
  endtask

  // place a word in decode with the given stage state, sample at the next negedge
  task automatic put(input logic [31:0] w, input logic [4:0] erd, input logic ewr, input logic eld,
                     input logic [4:0] mrd, input logic mwr, input logic mld,
                     input logic [4:0] wrd, input logic wwr,
                     input logic [31:0] ra, input logic [31:0] rb,
                     input logic [31:0] mv, input logic [31:0] wv);
    @(posedge clk); #1;
    idle_stages();
    fetch_word = w; fetch_pc = 32'h0000_3000;
    @(posedge clk); #1;
    fetch_word = NOP; fetch_pc = 32'h0000_3004;
    ex_rd = erd; ex_wr = ewr; ex_ld = eld;
    mem_rd = mrd; mem_wr = mwr; mem_load = mld;
    wb_rd = wrd; wb_wr = wwr;
    rf_rs1_val = ra; rf_rs2_val = rb; mem_fwd_val = mv; wb_fwd_val = wv;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int f3s[6] = '{0, 1, 4, 5, 6, 7};
    logic [31:0] pa[4] = '{32'd5, 32'd3, 32'd7, 32'hFFFF_FFFF};
    logic [31:0] pb[4] = '{32'd5, 32'd7, 32'd3, 32'd1};
    int imms[4] = '{16, -8, 2044, -4096};

    rst_n = 1'b0;
    idle_stages();
    fetch_word = FALL; fetch_pc = 32'h100;
    rf_rs1_val = 0; rf_rs2_val = 0; mem_fwd_val = 0; wb_fwd_val = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset word", dec_word, NOP);
    chk("R1", "reset pc", dec_pc, 0);
    #1 rst_n = 1'b1;
    fetch_word = NOP;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "word after reset", dec_word, NOP);
    chk("R1", "stall after reset", {31'd0, stall_fd}, 0);
    chk("R1", "redirect after reset", {31'd0, redirect_valid}, 0);

    for (int k = 0; k < 3; k++)
      for (int d = 0; d < 2; d++)
        for (int f = 0; f < 6; f++)
          for (int p = 0; p < 4; p++)
            run_case(k, d, f3s[f], pa[p], pb[p], imms[p]);

    // R8: producer with write flag low
    put(bword(3'd0, 5'd5, 5'd6, 13'd16), 5'd5, 1'b0, 1'b1, 5'd6, 1'b0, 1'b1, 5'd5, 1'b0,
        32'd9, 32'd9, 32'd1, 32'd2);
    chk("R8", "no stall when write off", {31'd0, stall_fd}, 0);
    chk("R8", "rf select when write off", fwd_sel_a, 0);
    chk("R8", "taken from rf", {31'd0, redirect_valid}, 1);

    // R8: destination x0, branch reads x0
    put(bword(3'd0, 5'd0, 5'd0, 13'd8), 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1,
        32'd0, 32'd0, 32'd7, 32'd8);
    chk("R8", "no stall on x0", {31'd0, stall_fd}, 0);
    chk("R8", "x0 select a", fwd_sel_a, 0);
    chk("R8", "x0 select b", fwd_sel_b, 0);

    // R11: memory beats write-back
    put(bword(3'd0, 5'd5, 5'd6, 13'd32), 5'd0, 1'b0, 1'b0, 5'd5, 1'b1, 1'b0, 5'd5, 1'b1,
        32'd1, 32'd44, 32'd44, 32'd2);
    chk("R11", "memory priority select", fwd_sel_a, 1);
    chk("R11", "taken with memory value", {31'd0, redirect_valid}, 1);
    chk("R11", "target", redirect_pc, 32'h0000_3020);

    // R10: non-branch word with a matching load in execute
    put(32'h0052_8293, 5'd5, 1'b1, 1'b1, 5'd5, 1'b1, 1'b1, 5'd0, 1'b0,
        32'd0, 32'd0, 32'd0, 32'd0);
    chk("R10", "non-branch no stall", {31'd0, stall_fd}, 0);
    chk("R10", "non-branch no redirect", {31'd0, redirect_valid}, 0);

    // R3: unsupported condition code 010 is not a branch
    put(bword(3'd2, 5'd5, 5'd6, 13'd8), 5'd5, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0,
        32'd3, 32'd3, 32'd0, 32'd0);
    chk("R3", "code 010 no stall", {31'd0, stall_fd}, 0);
    chk("R3", "code 010 no redirect", {31'd0, redirect_valid}, 0);

    // R7: load sitting in memory alone still stalls
    put(bword(3'd0, 5'd5, 5'd6, 13'd8), 5'd0, 1'b0, 1'b0, 5'd6, 1'b1, 1'b1, 5'd0, 1'b0,
        32'd3, 32'd3, 32'd3, 32'd3);
    chk("R7", "load in memory stalls", {31'd0, stall_fd}, 1);
    chk("R9", "no flush while stalled", {31'd0, flush_if}, 0);
    @(posedge clk); #1;
    idle_stages();
    fetch_word = NOP;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule